// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver

This block turns a recovered serial bit stream into the characters of a bit-oriented, HDLC-style frame. Each input bit arrives with a one-cycle valid strobe. The block does three things to the stream:

- It finds the flag sequence that opens and closes each frame.
- It deletes the zeros that the transmitter inserted after runs of ones.
- It groups the remaining bits, least significant bit first, into characters of a programmable width.

The 16 bits just before the closing flag form the check field. They never leave the block. A run of seven ones is reported on a pulse pin of its own. This run can be an abort, or a go-ahead in loop operation. It throws away the frame in progress. A frame that ends on a ragged bit count, or that holds no data character, raises a separate framing-error pulse.

Characters leave on a valid/ready stream port. Each beat carries three tags: start-of-message on the first character of a frame, end-of-message on the last, and an overrun tag. Back-pressure rules: a beat is taken on any cycle where both valid and ready are high. While valid is high and ready is low, the beat is held unchanged. The serial line cannot be stalled, so a character that completes while a beat is still waiting replaces that beat, and the overrun tag is set on the new beat. An optional station-address filter drops whole frames that are addressed to another station.

Top module: `hdlc_rx_framer`

## Requirements
- R1: The bit pattern 0,1,1,1,1,1,1,0 (six ones between zeros) delimits frames. The bits between an opening and a closing flag are delivered as characters, first received bit in bit 0. Back-to-back or shared-zero flags with no frame between them deliver nothing and raise no error.
- R2: A zero received directly after five consecutive ones is deleted. It is not counted as a data bit.
- R3: The final 16 data bits before the closing flag are treated as the check field. They are never delivered as characters.
- R4: The first character of a frame carries som=1, and the last carries eom=1. A frame with a single character carries both tags on the same beat.
- R5: On the seventh consecutive one, abort_ga_o pulses high for exactly one cycle, once per run of ones. The frame in progress is discarded: any character not yet delivered is never delivered, and no bits are taken until the next flag.
- R6: char_len_i selects the character width: 0 selects 5 bits, 1 selects 6, 2 selects 7, and 3 selects 8. Narrower characters are right-justified in m_data_o, and the unused high bits are zero.
- R7: When addr_en_i is 1, a frame is dropped up to the next flag if its first character equals neither station_addr_i nor 8'hFF. A dropped frame delivers no beats and raises no error. When addr_en_i is 0, all frames pass.
- R8: While m_valid_o=1 and m_ready_i=0, m_valid_o stays high and the beat stays stable until a new character completes. That new character replaces the held beat and sets m_ovr_o=1 on it. A beat accepted normally carries m_ovr_o=0.
- R9: If a closing flag ends a non-empty frame that either leaves a partial character or holds no complete data character before the check field, frame_err_o pulses for one cycle, and no eom beat is delivered for that frame.
- R10: After reset, m_valid_o, abort_ga_o and frame_err_o are 0. The block ignores all bits until it has seen a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Received serial bit |
| bit_vld_i | input | 1 | bit_i is valid this cycle |
| char_len_i | input | 2 | Character width select (5 + value bits) |
| addr_en_i | input | 1 | Enable the station-address filter |
| station_addr_i | input | 8 | Own station address for the filter |
| m_valid_o | output | 1 | Output beat valid |
| m_ready_i | input | 1 | Downstream accepts the beat |
| m_data_o | output | 8 | Received character, right-justified |
| m_som_o | output | 1 | Beat is the first character of a frame |
| m_eom_o | output | 1 | Beat is the last character of a frame |
| m_ovr_o | output | 1 | Beat replaced one that was never accepted |
| abort_ga_o | output | 1 | One-cycle pulse on seven consecutive ones |
| frame_err_o | output | 1 | One-cycle pulse on a malformed frame |

## Verification
Several corner cases are aimed at directly:

- Data bytes 8'hFF and 8'h7E force stuffed zeros. A receiver that keeps a stuffed zero, or that mistakes a data run of ones for a flag, delivers wrong or shifted characters.
- An abort arrives in mid-frame while a character is still inside the check-field holdback. A design that flushes instead of discarding leaks that character.
- A single-character frame tests the end-of-message tagging. Tagging only on the following character would leave eom off a lone character.
- Five-bit characters, a ragged bit count and a frame shorter than the check field check width selection and error reporting.
- A stalled sink covers the overrun path. A design that drops the new character rather than the old one shows the wrong data with eom clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_CW = 8;          // widest character
  localparam int unsigned RXF_FLAG_TAIL = 7;   // flag bits that enter the holdback

  typedef logic [RXF_CW-1:0] rxf_char_t;

  typedef struct packed {
    logic      ovr;
    logic      eom;
    logic      som;
    rxf_char_t data;
  } rxf_beat_t;

  typedef enum logic {RXF_HUNT = 1'b0, RXF_OPEN = 1'b1} rxf_mode_e;
endpackage

// File: rtl/rxf_destuff.sv
module rxf_destuff
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic vld_i,
  output logic dbit_v_o,
  output logic dbit_o,
  output logic flag_o,
  output logic abort_o
);
  localparam int unsigned RUN_W = 3;
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(7);

  logic [RUN_W-1:0] ones_q;
  rxf_mode_e        mode_q;

  always_comb begin
    dbit_v_o = 1'b0;
    dbit_o   = bit_i;
    flag_o   = 1'b0;
    abort_o  = 1'b0;
    if (vld_i) begin
      if (bit_i) begin
        if (ones_q == RUN_W'(6))        abort_o  = 1'b1;
        else if (ones_q != RUN_SAT && mode_q == RXF_OPEN) dbit_v_o = 1'b1;
      end else begin
        if (ones_q == RUN_W'(6))        flag_o   = 1'b1;
        else if (ones_q == RUN_W'(5))   dbit_v_o = 1'b0;   // stuffed zero dropped
        else if (ones_q != RUN_SAT && mode_q == RXF_OPEN) dbit_v_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      mode_q <= RXF_HUNT;
    end else if (vld_i) begin
      if (bit_i) ones_q <= (ones_q == RUN_SAT) ? RUN_SAT : ones_q + RUN_W'(1);
      else       ones_q <= '0;
      if (abort_o)     mode_q <= RXF_HUNT;
      else if (flag_o) mode_q <= RXF_OPEN;
    end
  end

  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RXF_HUNT) |-> !dbit_v_o);  // R10
  AST_STUFF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !bit_i && ones_q == RUN_W'(5)) |-> !dbit_v_o);  // R2
endmodule

// File: rtl/rxf_delay.sv
module rxf_delay #(
  parameter int unsigned DLY = 23,
  localparam int unsigned FW = $clog2(DLY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          bit_i,
  input  logic          clr_i,
  output logic          out_v_o,
  output logic          out_bit_o,
  output logic [FW-1:0] fill_o
);
  logic [DLY-1:0] sh_q;
  logic [FW-1:0]  fill_q;

  assign out_v_o   = push_i && (fill_q == FW'(DLY));
  assign out_bit_o = sh_q[DLY-1];
  assign fill_o    = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      fill_q <= '0;
    end else if (push_i) begin
      sh_q <= {sh_q[DLY-2:0], bit_i};
      if (fill_q != FW'(DLY)) fill_q <= fill_q + FW'(1);
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(DLY));  // R3
endmodule

// File: rtl/rxf_assem.sv
module rxf_assem
  import rxf_pkg::*;
#(
  parameter int unsigned LEN_W = 2,
  localparam int unsigned CW = RXF_CW,
  localparam int unsigned CNT_W = $clog2(CW + 1),
  localparam int unsigned MIN_BITS = CW - (2**LEN_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbit_v_i,
  input  logic             cbit_i,
  input  logic             flag_i,
  input  logic             abort_i,
  input  logic             nonempty_i,
  input  logic             full_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             addr_en_i,
  input  rxf_char_t        addr_i,
  input  logic             ready_i,
  output logic             valid_o,
  output rxf_beat_t        beat_o,
  output logic             err_o
);
  logic [CW-2:0] asm_q;
  logic [CNT_W-1:0] cnt_q;
  rxf_char_t pend_q;
  logic pend_v_q, pend_som_q, first_q, skip_q, err_q, valid_q;
  rxf_beat_t beat_q;

  logic [CNT_W-1:0] nbits;
  logic [CW-1:0]    asm_nxt;
  rxf_char_t        char_val;
  logic last_bit, char_done, addr_bad, close_ok, err_n;
  logic emit, e_som, e_eom;

  assign nbits     = CNT_W'(MIN_BITS) + CNT_W'(len_i);
  assign asm_nxt   = {cbit_i, asm_q};
  assign char_val  = rxf_char_t'(asm_nxt >> (CNT_W'(CW) - nbits));
  assign last_bit  = (cnt_q == nbits - CNT_W'(1));
  assign char_done = cbit_v_i && !skip_q && last_bit;
  assign addr_bad  = first_q && addr_en_i && (char_val != addr_i) && (char_val != {CW{1'b1}});
  assign close_ok  = flag_i && !skip_q && nonempty_i && full_i && (cnt_q == '0) && pend_v_q;
  assign err_n     = flag_i && !skip_q && nonempty_i && !close_ok;

  always_comb begin
    emit  = 1'b0;
    e_som = pend_som_q;
    e_eom = 1'b0;
    if (close_ok) begin
      emit  = 1'b1;
      e_eom = 1'b1;
    end else if (char_done && pend_v_q) begin
      emit  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q      <= '0;
      cnt_q      <= '0;
      pend_q     <= '0;
      pend_v_q   <= 1'b0;
      pend_som_q <= 1'b0;
      first_q    <= 1'b1;
      skip_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      err_q <= err_n;
      if (abort_i || flag_i) begin
        asm_q    <= '0;
        cnt_q    <= '0;
        pend_v_q <= 1'b0;
        first_q  <= 1'b1;
        skip_q   <= 1'b0;
      end else if (cbit_v_i && !skip_q) begin
        asm_q <= asm_nxt[CW-1:1];
        if (last_bit) begin
          cnt_q   <= '0;
          first_q <= 1'b0;
          if (addr_bad) begin
            skip_q <= 1'b1;
          end else begin
            pend_q     <= char_val;
            pend_v_q   <= 1'b1;
            pend_som_q <= first_q;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (emit) begin
      valid_q <= 1'b1;
      beat_q  <= '{ovr: valid_q && !ready_i, eom: e_eom, som: e_som, data: pend_q};
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign beat_o  = beat_q;
  assign err_o   = err_q;

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> valid_q);  // R8
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i && !emit) |=> $stable(beat_q));  // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i && emit) |=> beat_q.ovr);  // R8
  AST_ERR_NO_EOM: assert property (@(posedge clk) disable iff (!rst_n)
    err_n |-> !(emit && e_eom));  // R9
endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import rxf_pkg::*;
#(
  parameter int unsigned FCS_BITS = 16,
  parameter int unsigned LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic [LEN_W-1:0] char_len_i,
  input  logic             addr_en_i,
  input  logic [7:0]       station_addr_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [7:0]       m_data_o,
  output logic             m_som_o,
  output logic             m_eom_o,
  output logic             m_ovr_o,
  output logic             abort_ga_o,
  output logic             frame_err_o
);
  localparam int unsigned DLY = FCS_BITS + RXF_FLAG_TAIL;
  localparam int unsigned FW  = $clog2(DLY + 1);

  logic dbit_v, dbit, flag_p, abort_p;
  logic cbit_v, cbit;
  logic [FW-1:0] fill;
  logic abort_q;
  rxf_beat_t beat;

  rxf_destuff u_destuff (
    .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .vld_i(bit_vld_i),
    .dbit_v_o(dbit_v), .dbit_o(dbit), .flag_o(flag_p), .abort_o(abort_p)
  );

  rxf_delay #(.DLY(DLY)) u_delay (
    .clk(clk), .rst_n(rst_n), .push_i(dbit_v), .bit_i(dbit),
    .clr_i(flag_p || abort_p), .out_v_o(cbit_v), .out_bit_o(cbit), .fill_o(fill)
  );

  rxf_assem #(.LEN_W(LEN_W)) u_assem (
    .clk(clk), .rst_n(rst_n), .cbit_v_i(cbit_v), .cbit_i(cbit),
    .flag_i(flag_p), .abort_i(abort_p),
    .nonempty_i(fill > FW'(RXF_FLAG_TAIL)), .full_i(fill == FW'(DLY)),
    .len_i(char_len_i), .addr_en_i(addr_en_i), .addr_i(station_addr_i),
    .ready_i(m_ready_i), .valid_o(m_valid_o), .beat_o(beat), .err_o(frame_err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= abort_p;
  end

  assign abort_ga_o = abort_q;
  assign m_data_o   = beat.data;
  assign m_som_o    = beat.som;
  assign m_eom_o    = beat.eom;
  assign m_ovr_o    = beat.ovr;

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ga_o |=> !abort_ga_o);  // R5
endmodule

// File: tb/hdlc_rx_framer_tb_top.sv
module hdlc_rx_framer_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bit_i, bit_vld_i, addr_en_i, m_ready_i;
  logic [1:0] char_len_i;
  logic [7:0] station_addr_i, m_data_o;
  logic m_valid_o, m_som_o, m_eom_o, m_ovr_o, abort_ga_o, frame_err_o;

  hdlc_rx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .char_len_i(char_len_i), .addr_en_i(addr_en_i), .station_addr_i(station_addr_i),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_data_o(m_data_o),
    .m_som_o(m_som_o), .m_eom_o(m_eom_o), .m_ovr_o(m_ovr_o),
    .abort_ga_o(abort_ga_o), .frame_err_o(frame_err_o)
  );

  int total = 0, bad = 0, ab_cnt = 0, err_cnt = 0, tx_ones = 0;
  logic [10:0] got[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid_o && m_ready_i) got.push_back({m_ovr_o, m_eom_o, m_som_o, m_data_o});
      if (abort_ga_o) ab_cnt++;
      if (frame_err_o) err_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(posedge clk); #2;
    bit_i = b; bit_vld_i = 1'b1;
    @(posedge clk); #2;
    bit_vld_i = 1'b0;
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_sbit(input logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_char(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_sbit(v[i]);
  endtask

  task automatic send_fcs();
    send_char(8'hFF, 8);
    send_char(8'h3E, 8);
  endtask

  task automatic send_frame(input logic [7:0] d[$]);
    send_flag();
    foreach (d[i]) send_char(d[i], 8);
    send_fcs();
    send_flag();
    send_flag();
    repeat (4) @(posedge clk);
  endtask

  task automatic expect_beats(input string req, input logic [10:0] e[$]);
    chk(req, "beat count", got.size(), e.size());
    foreach (e[i]) if (i < got.size()) chk(req, "beat {ovr,eom,som,data}", got[i], e[i]);
    got.delete();
  endtask

  task automatic t_reset();
    chk("R10", "valid after reset", m_valid_o, 1'b0);
    chk("R10", "abort after reset", abort_ga_o, 1'b0);
    chk("R10", "error after reset", frame_err_o, 1'b0);
    send_char(8'h00, 8);
    send_char(8'h55, 8);
    send_char(8'h12, 8);
    repeat (4) @(posedge clk);
    chk("R10", "bits before first flag ignored", got.size(), 0);
    chk("R10", "no error before flag", err_cnt, 0);
  endtask

  task automatic t_basic();
    send_frame('{8'hFF, 8'h7E, 8'h3F});
    expect_beats("R2", '{11'h1FF, 11'h07E, 11'h23F});
    chk("R3", "check field not delivered", err_cnt, 0);
  endtask

  task automatic t_single();
    send_frame('{8'h3C});
    expect_beats("R4", '{11'h33C});
  endtask

  task automatic t_idle_flags();
    for (int i = 0; i < 5; i++) send_flag();
    repeat (4) @(posedge clk);
    chk("R1", "idle flags give no beats", got.size(), 0);
    chk("R1", "idle flags give no error", err_cnt, 0);
  endtask

  task automatic t_abort();
    int ab0 = ab_cnt;
    send_flag();
    send_char(8'h11, 8);
    send_char(8'h22, 8);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    repeat (4) @(posedge clk);
    chk("R5", "one abort pulse per run", ab_cnt - ab0, 1);
    chk("R5", "aborted frame delivers nothing", got.size(), 0);
    send_frame('{8'h55});
    expect_beats("R5", '{11'h355});
    chk("R5", "no error around abort", err_cnt, 0);
  endtask

  task automatic t_len5();
    char_len_i = 2'd0;
    send_flag();
    send_char(8'h15, 5);
    send_char(8'h0A, 5);
    send_char(8'h1F, 5);
    send_fcs();
    send_flag();
    send_flag();
    repeat (4) @(posedge clk);
    expect_beats("R6", '{11'h115, 11'h00A, 11'h21F});
    char_len_i = 2'd3;
  endtask

  task automatic t_addr();
    addr_en_i = 1'b1; station_addr_i = 8'h42;
    send_frame('{8'h43, 8'h01});
    expect_beats("R7", '{});
    chk("R7", "dropped frame not an error", err_cnt, 0);
    send_frame('{8'h42, 8'h05});
    expect_beats("R7", '{11'h142, 11'h205});
    send_frame('{8'hFF, 8'h09});
    expect_beats("R7", '{11'h1FF, 11'h209});
    addr_en_i = 1'b0;
    send_frame('{8'h43, 8'h01});
    expect_beats("R7", '{11'h143, 11'h201});
  endtask

  task automatic t_overrun();
    @(posedge clk); #2; m_ready_i = 1'b0;
    send_frame('{8'hA1, 8'hB2, 8'hC3});
    @(negedge clk);
    chk("R8", "valid held", m_valid_o, 1'b1);
    chk("R8", "held beat", {m_ovr_o, m_eom_o, m_som_o, m_data_o}, 11'h6C3);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R8", "beat stable under stall", {m_valid_o, m_ovr_o, m_eom_o, m_som_o, m_data_o}, 12'hEC3);
    @(posedge clk); #2; m_ready_i = 1'b1;
    repeat (3) @(posedge clk);
    expect_beats("R8", '{11'h6C3});
    chk("R8", "valid drops after accept", m_valid_o, 1'b0);
  endtask

  task automatic t_error();
    int e0 = err_cnt;
    send_flag();
    send_char(8'hAB, 8);
    send_char(8'h05, 4);
    send_fcs();
    send_flag();
    send_flag();
    repeat (4) @(posedge clk);
    chk("R9", "ragged frame error", err_cnt - e0, 1);
    expect_beats("R9", '{});
    send_flag();
    send_char(8'h33, 8);
    send_flag();
    send_flag();
    repeat (4) @(posedge clk);
    chk("R9", "short frame error", err_cnt - e0, 2);
    expect_beats("R9", '{});
    send_frame('{8'h77});
    expect_beats("R1", '{11'h377});
  endtask

  initial begin
    rst_n = 1'b0; bit_i = 1'b0; bit_vld_i = 1'b0; char_len_i = 2'd3;
    addr_en_i = 1'b0; station_addr_i = 8'h00; m_ready_i = 1'b1;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single();
    t_idle_flags();
    t_abort();
    t_len5();
    t_addr();
    t_overrun();
    t_error();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule